// File: doc/BRIEF.md
# Dual-Issue Pairing Gate

This block sits at the issue stage of a two-thread in-order core. Each cycle the stage presents up to two instructions: an older one and a younger one. The older one always goes out when it is valid. This gate only decides whether the younger one may go out in the same cycle.

The decision rests on five things. The first is the execution route each instruction targets. The second is whether either instruction needs microcode expansion. The third is a set of cross-thread conflicts on shared registers and synchronisation. The fourth is how recently a reciprocal-estimate instruction went out. The fifth is whether the latest vector/scalar instruction was an arithmetic one.

The gate keeps a short history of what actually issued, so its timing rules follow the real issue stream. It does not look at register data hazards and it does not execute anything.

Top module: `dual_issue_gate`

## Requirements
- R1: When the older slot is valid, `issueOld` is 1. When the older slot is invalid, `issueOld` and `issuePair` are both 0.
- R2: The pair is refused when both instructions name the same route. The route codes are 0 branch, 1 fixed-point, 2 load/store, 3 vector/scalar arithmetic (type 1) and 4 vector/scalar load/store/permute (type 2). Codes 3 and 4 count as different routes. Codes 5 to 7 are reserved, and any slot carrying one is never paired.
- R3: The pair is refused when either instruction has its microcode flag set.
- R4: The pair is refused when either slot holds a synchronising instruction whose thread number is 0. A synchronising instruction of thread 1 does not block.
- R5: For instructions of different threads, the pair is refused when both access the condition register, or when both access the link register. For instructions of the same thread, these flags do not block.
- R6: A SIMD-float instruction in either slot blocks the pair when a reciprocal-estimate instruction issued in either of the two previous cycles. It also blocks when the younger slot is SIMD-float and the older slot is a reciprocal estimate in the same cycle. Three cycles after the estimate, pairing is allowed again. A reciprocal estimate in the younger slot counts as issued only when the pair issued.
- R7: A move-from-FP-status instruction in either slot blocks the pair when the most recently issued vector/scalar instruction had route code 3. The same applies when the older slot holds route code 3 and the younger slot is the move instruction. Issuing a route-4 instruction clears this condition.
- R8: A valid younger slot with an invalid older slot raises `slotFault`, and nothing issues.
- R9: After reset the history is empty. A SIMD-float instruction and a move-from-FP-status instruction may then pair with no earlier blocking instruction.
- R10: `issuePair` is 0 whenever the younger slot is invalid. When both slots are valid and no rule of R2 to R7 applies, `issuePair` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| oldValid | input | 1 | Older slot holds an instruction |
| oldRoute | input | 3 | Older route code |
| oldThread | input | THREAD_W | Older thread number |
| oldMicro | input | 1 | Older needs microcode |
| oldCr | input | 1 | Older accesses condition register |
| oldLr | input | 1 | Older accesses link register |
| oldSimdFp | input | 1 | Older is SIMD float |
| oldRecip | input | 1 | Older is reciprocal estimate |
| oldFsRead | input | 1 | Older moves from FP status register |
| oldSync | input | 1 | Older is synchronising |
| yngValid | input | 1 | Younger slot holds an instruction |
| yngRoute | input | 3 | Younger route code |
| yngThread | input | THREAD_W | Younger thread number |
| yngMicro | input | 1 | Younger needs microcode |
| yngCr | input | 1 | Younger accesses condition register |
| yngLr | input | 1 | Younger accesses link register |
| yngSimdFp | input | 1 | Younger is SIMD float |
| yngRecip | input | 1 | Younger is reciprocal estimate |
| yngFsRead | input | 1 | Younger moves from FP status register |
| yngSync | input | 1 | Younger is synchronising |
| issueOld | output | 1 | Older instruction issues this cycle |
| issuePair | output | 1 | Younger issues together with the older |
| slotFault | output | 1 | Younger valid while older invalid |

## Verification
The hardest situations to reach are the history-driven refusals, because they depend on what issued in earlier cycles. The estimate window is one such case. The bench places a reciprocal estimate and then probes SIMD-float pairs one, two and three cycles later. It also tests an estimate in the younger slot that was itself refused, which must leave no trace. The status-read rule is handled the same way. The bench issues a route-3 instruction, then places idle or unrelated cycles in between, then checks that a route-4 issue clears the condition. Long random runs also keep a bench-side copy of the history, so these states are reached in many orders.

// File: rtl/dual_issue_pkg.sv
package dual_issue_pkg;
  parameter int THREAD_W = 1;
  parameter int ROUTE_W  = 3;

  localparam logic [ROUTE_W-1:0] RT_BRANCH = 3'd0;
  localparam logic [ROUTE_W-1:0] RT_FIXED  = 3'd1;
  localparam logic [ROUTE_W-1:0] RT_LDST   = 3'd2;
  localparam logic [ROUTE_W-1:0] RT_VARITH = 3'd3;
  localparam logic [ROUTE_W-1:0] RT_VMOVE  = 3'd4;

  typedef struct packed {
    logic                valid;
    logic [ROUTE_W-1:0]  route;
    logic [THREAD_W-1:0] thread;
    logic                micro;
    logic                cr;
    logic                lr;
    logic                simdFp;
    logic                recip;
    logic                fsRead;
    logic                sync;
  } slot_t;

  typedef struct packed {
    logic recipIssued;
    logic vecIssued;
    logic vecArith;
  } hist_strobe_t;
endpackage

// File: rtl/issue_history.sv
module issue_history
  import dual_issue_pkg::*;
#(
  parameter int HIST_DEPTH = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  hist_strobe_t strobe,
  output logic         recipRecent,
  output logic         lastArith
);
  logic [HIST_DEPTH-1:0] recipHist;

  always_ff @(posedge clk) begin
    if (!rstN) recipHist[0] <= 1'b0;
    else       recipHist[0] <= strobe.recipIssued;
  end

  generate
    for (genvar s = 1; s < HIST_DEPTH; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rstN) recipHist[s] <= 1'b0;
        else       recipHist[s] <= recipHist[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN)                 lastArith <= 1'b0;
    else if (strobe.vecIssued) lastArith <= strobe.vecArith;
  end

  assign recipRecent = |recipHist;

  a_r6_estimate_remembered: assert property (@(posedge clk) disable iff (!rstN)
    strobe.recipIssued |=> recipRecent);

  a_r7_arith_tracked: assert property (@(posedge clk) disable iff (!rstN)
    strobe.vecIssued |=> (lastArith == $past(strobe.vecArith)));

  a_r7_arith_held: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.vecIssued |=> $stable(lastArith));
endmodule

// File: rtl/pair_rules.sv
module pair_rules
  import dual_issue_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  slot_t        oldSlot,
  input  slot_t        yngSlot,
  input  logic         recipRecent,
  input  logic         lastArith,
  output logic         issueOld,
  output logic         issuePair,
  output logic         slotFault,
  output hist_strobe_t strobe
);
  localparam int NRULES = 6;

  logic [NRULES-1:0] blockVec;
  logic oldReserved, yngReserved, sameRoute, crossThread;
  logic oldVec, yngVec;

  always_comb begin
    oldReserved = oldSlot.route > RT_VMOVE;
    yngReserved = yngSlot.route > RT_VMOVE;
    sameRoute   = oldSlot.route == yngSlot.route;
    crossThread = oldSlot.thread != yngSlot.thread;
    oldVec      = (oldSlot.route == RT_VARITH) || (oldSlot.route == RT_VMOVE);
    yngVec      = (yngSlot.route == RT_VARITH) || (yngSlot.route == RT_VMOVE);

    blockVec[0] = sameRoute || oldReserved || yngReserved;
    blockVec[1] = oldSlot.micro || yngSlot.micro;
    blockVec[2] = (oldSlot.sync && (oldSlot.thread == '0)) ||
                  (yngSlot.sync && (yngSlot.thread == '0));
    blockVec[3] = crossThread &&
                  ((oldSlot.cr && yngSlot.cr) || (oldSlot.lr && yngSlot.lr));
    blockVec[4] = ((oldSlot.simdFp || yngSlot.simdFp) && recipRecent) ||
                  (yngSlot.simdFp && oldSlot.recip);
    blockVec[5] = ((oldSlot.fsRead || yngSlot.fsRead) && lastArith) ||
                  (yngSlot.fsRead && (oldSlot.route == RT_VARITH));
  end

  always_comb begin
    issueOld  = oldSlot.valid;
    slotFault = yngSlot.valid && !oldSlot.valid;
    issuePair = oldSlot.valid && yngSlot.valid && !(|blockVec);
  end

  always_comb begin
    strobe.recipIssued = (issueOld && oldSlot.recip) || (issuePair && yngSlot.recip);
    strobe.vecIssued   = (issueOld && oldVec) || (issuePair && yngVec);
    if (issuePair && yngVec) strobe.vecArith = yngSlot.route == RT_VARITH;
    else                     strobe.vecArith = oldSlot.route == RT_VARITH;
  end

  a_r2_distinct_routes: assert property (@(posedge clk) disable iff (!rstN)
    issuePair |-> (oldSlot.route != yngSlot.route));

  a_r3_no_microcode_pair: assert property (@(posedge clk) disable iff (!rstN)
    issuePair |-> !(oldSlot.micro || yngSlot.micro));

  a_r8_fault_silences: assert property (@(posedge clk) disable iff (!rstN)
    slotFault |-> !issueOld && !issuePair);

  a_r10_pair_needs_old: assert property (@(posedge clk) disable iff (!rstN)
    issuePair |-> issueOld && yngSlot.valid);

  a_r6_window_respected: assert property (@(posedge clk) disable iff (!rstN)
    (issuePair && (oldSlot.simdFp || yngSlot.simdFp)) |-> !recipRecent);
endmodule

// File: rtl/dual_issue_gate.sv
module dual_issue_gate
  import dual_issue_pkg::*;
#(
  parameter int HIST_DEPTH = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                oldValid,
  input  logic [ROUTE_W-1:0]  oldRoute,
  input  logic [THREAD_W-1:0] oldThread,
  input  logic                oldMicro,
  input  logic                oldCr,
  input  logic                oldLr,
  input  logic                oldSimdFp,
  input  logic                oldRecip,
  input  logic                oldFsRead,
  input  logic                oldSync,
  input  logic                yngValid,
  input  logic [ROUTE_W-1:0]  yngRoute,
  input  logic [THREAD_W-1:0] yngThread,
  input  logic                yngMicro,
  input  logic                yngCr,
  input  logic                yngLr,
  input  logic                yngSimdFp,
  input  logic                yngRecip,
  input  logic                yngFsRead,
  input  logic                yngSync,
  output logic                issueOld,
  output logic                issuePair,
  output logic                slotFault
);
  slot_t        oldSlot, yngSlot;
  hist_strobe_t strobe;
  logic         recipRecent, lastArith;

  assign oldSlot = '{valid: oldValid, route: oldRoute, thread: oldThread,
                     micro: oldMicro, cr: oldCr, lr: oldLr, simdFp: oldSimdFp,
                     recip: oldRecip, fsRead: oldFsRead, sync: oldSync};
  assign yngSlot = '{valid: yngValid, route: yngRoute, thread: yngThread,
                     micro: yngMicro, cr: yngCr, lr: yngLr, simdFp: yngSimdFp,
                     recip: yngRecip, fsRead: yngFsRead, sync: yngSync};

  pair_rules u_rules (
    .clk(clk), .rstN(rstN), .oldSlot(oldSlot), .yngSlot(yngSlot),
    .recipRecent(recipRecent), .lastArith(lastArith),
    .issueOld(issueOld), .issuePair(issuePair), .slotFault(slotFault),
    .strobe(strobe)
  );

  issue_history #(.HIST_DEPTH(HIST_DEPTH)) u_hist (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .recipRecent(recipRecent), .lastArith(lastArith)
  );

  a_r1_old_always_goes: assert property (@(posedge clk) disable iff (!rstN)
    oldValid |-> issueOld);
endmodule

// File: tb/sim_dual_issue_gate.sv
module sim_dual_issue_gate;
  import dual_issue_pkg::*;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rstN = 0;
  slot_t o, y;
  logic issueOld, issuePair, slotFault;
  int compared = 0, mismatched = 0;
  logic [1:0] mRecip;
  logic mArith;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_issue_gate u0 (
    .clk(clk), .rstN(rstN),
    .oldValid(o.valid), .oldRoute(o.route), .oldThread(o.thread), .oldMicro(o.micro),
    .oldCr(o.cr), .oldLr(o.lr), .oldSimdFp(o.simdFp), .oldRecip(o.recip),
    .oldFsRead(o.fsRead), .oldSync(o.sync),
    .yngValid(y.valid), .yngRoute(y.route), .yngThread(y.thread), .yngMicro(y.micro),
    .yngCr(y.cr), .yngLr(y.lr), .yngSimdFp(y.simdFp), .yngRecip(y.recip),
    .yngFsRead(y.fsRead), .yngSync(y.sync),
    .issueOld(issueOld), .issuePair(issuePair), .slotFault(slotFault));

  function automatic slot_t mk(logic [2:0] r, logic [THREAD_W-1:0] t);
    slot_t s = '0;
    s.valid = 1; s.route = r; s.thread = t;
    return s;
  endfunction

  function automatic logic isVec(logic [2:0] r);
    return r == 3'd3 || r == 3'd4;
  endfunction

  function automatic logic expPair(slot_t a, slot_t b, logic rr, logic la);
    logic blk;
    if (!a.valid || !b.valid) return 1'b0;
    blk = (a.route == b.route) || a.route > 3'd4 || b.route > 3'd4;
    blk |= a.micro | b.micro;
    blk |= (a.sync && a.thread == 0) || (b.sync && b.thread == 0);
    blk |= (a.thread != b.thread) && ((a.cr && b.cr) || (a.lr && b.lr));
    blk |= ((a.simdFp || b.simdFp) && rr) || (b.simdFp && a.recip);
    blk |= ((a.fsRead || b.fsRead) && la) || (b.fsRead && a.route == 3'd3);
    return !blk;
  endfunction

  task automatic step(slot_t a, slot_t b, string tag);
    logic eOld, ePair, eFault, rin;
    @(negedge clk);
    o = a; y = b;
    #(CLK_PERIOD/4);
    eOld = a.valid;
    ePair = expPair(a, b, |mRecip, mArith);
    eFault = b.valid && !a.valid;
    compared++;
    if ({issueOld, issuePair, slotFault} !== {eOld, ePair, eFault}) begin
      mismatched++;
      $display("FAIL %s: old/pair/fault got %b%b%b expected %b%b%b", tag,
               issueOld, issuePair, slotFault, eOld, ePair, eFault);
    end
    rin = (eOld && a.recip) || (ePair && b.recip);
    mRecip = {mRecip[0], rin};
    if (ePair && isVec(b.route)) mArith = b.route == 3'd3;
    else if (eOld && isVec(a.route)) mArith = a.route == 3'd3;
  endtask

  function automatic slot_t rnd();
    slot_t s;
    int u = $urandom_range(0, 15);
    s.valid  = $urandom_range(0, 9) != 0;
    s.route  = (u < 14) ? 3'($urandom_range(0, 4)) : 3'($urandom_range(5, 7));
    s.thread = THREAD_W'($urandom_range(0, 1));
    s.micro  = $urandom_range(0, 11) == 0;
    s.cr     = $urandom_range(0, 3) == 0;
    s.lr     = $urandom_range(0, 3) == 0;
    s.simdFp = $urandom_range(0, 3) == 0;
    s.recip  = $urandom_range(0, 4) == 0;
    s.fsRead = $urandom_range(0, 4) == 0;
    s.sync   = $urandom_range(0, 9) == 0;
    return s;
  endfunction

  initial begin
    #(CLK_PERIOD*200000);
    mismatched++;
    $display("FAIL watchdog: expired, got hang expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    slot_t a, b, n;
    void'($urandom(32'd1234));
    o = '0; y = '0; mRecip = 0; mArith = 0; n = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;
    // R9 reset state: simd and status read pair freely
    a = mk(3'd1, 0); b = mk(3'd4, 1); b.simdFp = 1; b.fsRead = 1;
    step(a, b, "R9 clean history");
    step(n, n, "R1 idle");
    a = mk(3'd0, 0); step(a, n, "R10 young invalid");
    step(n, mk(3'd1, 0), "R8 fault");
    step(mk(3'd1, 0), mk(3'd1, 1), "R2 same route");
    step(mk(3'd3, 0), mk(3'd4, 0), "R2 vec types distinct");
    step(mk(3'd5, 0), mk(3'd1, 0), "R2 reserved code");
    a = mk(3'd0, 0); a.micro = 1; step(a, mk(3'd1, 1), "R3 micro");
    a = mk(3'd0, 1); a.sync = 1; step(a, mk(3'd1, 1), "R4 thread1 sync ok");
    b = mk(3'd1, 0); b.sync = 1; step(mk(3'd0, 1), b, "R4 thread0 sync");
    a = mk(3'd0, 0); a.cr = 1; b = mk(3'd1, 1); b.cr = 1; step(a, b, "R5 cross cr");
    b.thread = 0; step(a, b, "R5 same thread cr");
    a.cr = 0; a.lr = 1; b.cr = 0; b.lr = 1; b.thread = 1; step(a, b, "R5 cross lr");
    // R6 estimate window
    a = mk(3'd4, 0); a.recip = 1; step(a, n, "R6 estimate");
    b = mk(3'd3, 1); b.simdFp = 1;
    step(mk(3'd1, 0), b, "R6 +1 blocked");
    step(mk(3'd1, 0), b, "R6 +2 blocked");
    step(mk(3'd1, 0), b, "R6 +3 allowed");
    a = mk(3'd4, 0); a.recip = 1; step(a, b, "R6 same cycle");
    step(n, n, "R6 gap"); step(n, n, "R6 gap");
    b = mk(3'd4, 1); b.recip = 1; a = mk(3'd4, 0);
    step(a, b, "R6 refused estimate");
    b = mk(3'd3, 1); b.simdFp = 1;
    step(mk(3'd1, 0), b, "R6 refused estimate leaves none");
    // R7 status read
    step(mk(3'd3, 0), n, "R7 arith");
    step(n, n, "R7 gap");
    b = mk(3'd4, 1); b.fsRead = 1; step(mk(3'd1, 0), b, "R7 blocked");
    step(mk(3'd4, 0), n, "R7 move clears");
    step(mk(3'd1, 0), b, "R7 allowed");
    b = mk(3'd1, 1); b.fsRead = 1; step(mk(3'd3, 0), b, "R7 same cycle");
    repeat (4000) step(rnd(), rnd(), "random mix");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule